// File: doc/BRIEF.md
# Shared SMBus Slot Isolation Controller

This block manages one upstream SMBus/I2C host segment that fans out to several slot branches. At most one branch is connected at a time through a per-slot gate enable. A host request to move to another branch is held until the shared bus is idle, and the new branch is connected only after both of its lines have been seen high for a settle interval. A stuck branch can therefore never pull down the shared segment.

While a branch is connected, its clock and data lines are watched for being held low. When a line stays low for a bounded number of cycles, the branch is cut off and marked isolated, and a timeout flag is raised. A recovery sequence then pulses a reset to that branch and re-enumerates it by waiting for both lines to return high. If that works, the slot is reconnected through the normal idle and settle path. If it does not, the slot stays isolated and every other slot stays selectable.

Address NACK and data-integrity errors come from the external protocol engine as single-cycle pulses. They are logged against the connected slot in separate sticky bits, alongside a saturating per-slot fault counter. An alert line is driven high while any fault bit is set, and the host clears each slot's status with a write-one-to-clear mask.

Top module: `smbus_slot_guard`

## Requirements
- R1: After reset, all gate enables, reset pulses, isolation bits, fault bits and counters are 0, and alert is low. No slot is connected until a select request arrives.
- R2: At most one gate enable is high at any time. A select request for a slot that is in range and not isolated connects exactly that slot once the bus is idle and the slot has settled.
- R3: A change of connected slot takes effect only when the bus is idle. Idle means no START is pending a STOP, and the combined SCL and SDA have both been high for IDLE_CYC cycles since the last STOP. A request made mid-transfer leaves the current gate unchanged until after the STOP.
- R4: A newly selected slot's gate rises only after both of its lines have been high for SETTLE_CYC consecutive cycles. Counted from the cycle the request is sampled on an idle bus, the gate is high after exactly SETTLE_CYC+2 clock edges.
- R5: If SCL or SDA of the connected slot is low for TIMEOUT_CYC consecutive cycles, the gate opens on the next edge. The slot's timeout bit and isolation bit are set, and its counter increments.
- R6: Recovery after a fault runs in this order: slot reset pulse high for RST_CYC cycles with the gate open, then re-enumeration. If both lines are high for SETTLE_CYC cycles within TIMEOUT_CYC cycles, isolation clears and the slot reconnects through the idle and settle path. If not, the slot remains isolated and no gate is connected.
- R7: A select request naming an isolated slot is ignored, and other slots remain selectable.
- R8: An address-NACK pulse sets the connected slot's NACK bit, and a data-error pulse sets its data-error bit. Each increments that slot's counter. The connection is unaffected.
- R9: Alert is high exactly while any slot has a NACK, timeout or data-error bit set.
- R10: Each slot's CNT_W-bit fault counter saturates at its all-ones value.
- R11: A 1 in bit i of the clear mask, in one cycle, zeroes slot i's three fault bits, its counter and its isolation bit. Other slots are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostScl | input | 1 | Sampled upstream clock line |
| hostSda | input | 1 | Sampled upstream data line |
| slotScl | input | NUM_SLOTS | Sampled clock line of each branch |
| slotSda | input | NUM_SLOTS | Sampled data line of each branch |
| selReq | input | 1 | Select request strobe |
| selSlot | input | IDX_W | Requested slot index |
| nackEvt | input | 1 | Address NACK seen on connected slot (pulse) |
| crcEvt | input | 1 | Data-integrity error on connected slot (pulse) |
| clrMask | input | NUM_SLOTS | Write-one-to-clear per slot status |
| gateEn | output | NUM_SLOTS | Per-slot gate enable, one-hot or zero |
| slotRst | output | NUM_SLOTS | Per-slot branch reset pulse |
| isoMask | output | NUM_SLOTS | Slot isolated |
| nackFlag | output | NUM_SLOTS | Sticky address NACK bit |
| tmoFlag | output | NUM_SLOTS | Sticky timeout/stuck-low bit |
| crcFlag | output | NUM_SLOTS | Sticky data-integrity bit |
| faultCnt | output | NUM_SLOTS*CNT_W | Saturating fault counters, slot i at bits i*CNT_W upward |
| alert | output | 1 | Any sticky fault bit set |
| recovering | output | 1 | Reset or re-enumeration in progress |

## Verification
The hardest case to reach is a successful recovery. A connected branch must stay stuck long enough to time out, and then be freed by its own reset pulse, so that re-enumeration succeeds and the slot reconnects by itself. The bench models the branch by holding its data line low and releasing it in the cycle the reset pulse is observed. It then watches for isolation to clear and the gate to come back without any new select. A second hard case is a select made between START and STOP, which the bench creates by driving a host-side START and several clock pulses before issuing the request.

// File: rtl/slot_guard_pkg.sv
`timescale 1ns/1ps
package slot_guard_pkg;
  localparam int MAX_IDX_W = 4;

  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT, ST_SETTLE, ST_ON, ST_RST, ST_REENUM
  } ctl_state_e;

  typedef struct packed {
    logic                 linkUp;
    logic                 faultCut;
    logic                 enumOk;
    logic [MAX_IDX_W-1:0] slot;
  } ctl_strobe_t;
endpackage

// File: rtl/slot_guard_monitor.sv
`timescale 1ns/1ps
module slot_guard_monitor #(
  parameter int IDLE_CYC    = 4,
  parameter int TIMEOUT_CYC = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostScl,
  input  logic hostSda,
  input  logic brScl,
  input  logic brSda,
  input  logic watch,
  input  logic flush,
  output logic busIdle,
  output logic stuckLow
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic busScl, busSda, prevScl, prevSda, inXfer, startDet, stopDet;
  logic [IW-1:0] idleCnt;
  logic [1:0] lineLow;
  logic [1:0] lineStuck;

  always_comb begin
    busScl   = hostScl & brScl;
    busSda   = hostSda & brSda;
    startDet = prevScl & busScl & prevSda & ~busSda;
    stopDet  = prevScl & busScl & ~prevSda & busSda;
    busIdle  = !inXfer && (idleCnt == IW'(IDLE_CYC)) && busScl && busSda;
    lineLow  = {~brSda, ~brScl};
    stuckLow = |lineStuck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
      inXfer  <= 1'b0;
      idleCnt <= '0;
    end else begin
      prevScl <= busScl;
      prevSda <= busSda;
      if (flush) begin
        inXfer  <= 1'b0;
        idleCnt <= '0;
      end else begin
        if (startDet)     inXfer <= 1'b1;
        else if (stopDet) inXfer <= 1'b0;
        if (!busScl || !busSda || startDet || (inXfer && !stopDet))
          idleCnt <= '0;
        else if (idleCnt != IW'(IDLE_CYC))
          idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gLowTimer
    logic [TW-1:0] lowCnt;
    always_ff @(posedge clk) begin
      if (!rstN || !watch || !lineLow[g]) lowCnt <= '0;
      else if (lowCnt != TW'(TIMEOUT_CYC)) lowCnt <= lowCnt + 1'b1;
    end
    assign lineStuck[g] = (lowCnt == TW'(TIMEOUT_CYC));
  end
endmodule

// File: rtl/slot_guard_ctrl.sv
`timescale 1ns/1ps
module slot_guard_ctrl
  import slot_guard_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int IDX_W       = 2,
  parameter int TIMEOUT_CYC = 32,
  parameter int SETTLE_CYC  = 6,
  parameter int RST_CYC     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 selReq,
  input  logic [IDX_W-1:0]     selSlot,
  input  logic [NUM_SLOTS-1:0] slotScl,
  input  logic [NUM_SLOTS-1:0] slotSda,
  input  logic [NUM_SLOTS-1:0] isoMask,
  input  logic                 busIdle,
  input  logic                 stuckLow,
  output ctl_strobe_t          strobe,
  output logic [NUM_SLOTS-1:0] gateEn,
  output logic [NUM_SLOTS-1:0] slotRst,
  output logic                 recovering
);
  localparam int MAXC = (TIMEOUT_CYC > RST_CYC) ? TIMEOUT_CYC : RST_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int SW   = $clog2(SETTLE_CYC + 1);

  ctl_state_e state;
  logic [IDX_W-1:0] act, pend;
  logic conn;
  logic [TW-1:0] tmr;
  logic [SW-1:0] run;
  logic [NUM_SLOTS-1:0] actOneHot;
  logic tgtHigh, selOk, linked, settleDone, tmrExpired, faultNow, enumDone;

  always_comb begin
    actOneHot  = NUM_SLOTS'(1) << act;
    tgtHigh    = slotScl[act] & slotSda[act];
    selOk      = selReq && (int'(selSlot) < NUM_SLOTS) && !isoMask[selSlot];
    linked     = (state == ST_ON) || ((state == ST_WAIT) && conn);
    settleDone = tgtHigh && (run == SW'(SETTLE_CYC - 1));
    tmrExpired = (tmr == TW'(TIMEOUT_CYC - 1));
    faultNow   = (linked && stuckLow) ||
                 ((state == ST_SETTLE) && !settleDone && tmrExpired);
    enumDone   = (state == ST_REENUM) && settleDone;
    gateEn     = linked ? actOneHot : '0;
    slotRst    = (state == ST_RST) ? actOneHot : '0;
    recovering = (state == ST_RST) || (state == ST_REENUM);
    strobe.linkUp   = linked;
    strobe.faultCut = faultNow;
    strobe.enumOk   = enumDone;
    strobe.slot     = MAX_IDX_W'(act);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OFF;
      act   <= '0;
      pend  <= '0;
      conn  <= 1'b0;
      tmr   <= '0;
      run   <= '0;
    end else begin
      case (state)
        ST_OFF: if (selOk) begin
          pend  <= selSlot;
          state <= ST_WAIT;
        end
        ST_ON: begin
          if (faultNow) begin
            conn  <= 1'b0;
            tmr   <= '0;
            state <= ST_RST;
          end else if (selOk && selSlot != act) begin
            pend  <= selSlot;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (faultNow) begin
            conn  <= 1'b0;
            tmr   <= '0;
            state <= ST_RST;
          end else if (selOk) begin
            pend <= selSlot;
          end else if (busIdle) begin
            act   <= pend;
            conn  <= 1'b0;
            tmr   <= '0;
            run   <= '0;
            state <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settleDone) begin
            conn  <= 1'b1;
            state <= ST_ON;
          end else if (tmrExpired) begin
            tmr   <= '0;
            state <= ST_RST;
          end else begin
            tmr <= tmr + 1'b1;
            run <= tgtHigh ? run + 1'b1 : '0;
          end
        end
        ST_RST: begin
          if (tmr == TW'(RST_CYC - 1)) begin
            tmr   <= '0;
            run   <= '0;
            state <= ST_REENUM;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_REENUM: begin
          if (enumDone) begin
            pend  <= act;
            state <= ST_WAIT;
          end else if (tmrExpired) begin
            state <= ST_OFF;
          end else begin
            tmr <= tmr + 1'b1;
            run <= tgtHigh ? run + 1'b1 : '0;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/slot_guard_status.sv
`timescale 1ns/1ps
module slot_guard_status
  import slot_guard_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctl_strobe_t                  strobe,
  input  logic                         nackEvt,
  input  logic                         crcEvt,
  input  logic [NUM_SLOTS-1:0]         clrMask,
  output logic [NUM_SLOTS-1:0]         isoMask,
  output logic [NUM_SLOTS-1:0]         nackFlag,
  output logic [NUM_SLOTS-1:0]         tmoFlag,
  output logic [NUM_SLOTS-1:0]         crcFlag,
  output logic [NUM_SLOTS*CNT_W-1:0]   faultCnt,
  output logic                         alert
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    logic hit, nackHit, crcHit, tmoHit, okHit, anyHit;
    logic nF, tF, cF, iF;
    logic [CNT_W-1:0] cnt, base;

    always_comb begin
      hit     = (strobe.slot == MAX_IDX_W'(i));
      nackHit = strobe.linkUp & hit & nackEvt;
      crcHit  = strobe.linkUp & hit & crcEvt;
      tmoHit  = strobe.faultCut & hit;
      okHit   = strobe.enumOk & hit;
      anyHit  = nackHit | crcHit | tmoHit;
      base    = clrMask[i] ? '0 : cnt;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        nF  <= 1'b0;
        tF  <= 1'b0;
        cF  <= 1'b0;
        iF  <= 1'b0;
        cnt <= '0;
      end else begin
        nF  <= nackHit | (nF & ~clrMask[i]);
        cF  <= crcHit  | (cF & ~clrMask[i]);
        tF  <= tmoHit  | (tF & ~clrMask[i]);
        iF  <= tmoHit  | (iF & ~clrMask[i] & ~okHit);
        cnt <= (anyHit && base != CNT_MAX) ? base + 1'b1 : base;
      end
    end

    assign nackFlag[i] = nF;
    assign tmoFlag[i]  = tF;
    assign crcFlag[i]  = cF;
    assign isoMask[i]  = iF;
    assign faultCnt[i*CNT_W +: CNT_W] = cnt;
  end

  assign alert = |{nackFlag, tmoFlag, crcFlag};
endmodule

// File: rtl/smbus_slot_guard.sv
`timescale 1ns/1ps
module smbus_slot_guard
  import slot_guard_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int TIMEOUT_CYC = 32,
  parameter int SETTLE_CYC  = 6,
  parameter int IDLE_CYC    = 4,
  parameter int RST_CYC     = 4,
  parameter int CNT_W       = 3,
  localparam int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostScl,
  input  logic                       hostSda,
  input  logic [NUM_SLOTS-1:0]       slotScl,
  input  logic [NUM_SLOTS-1:0]       slotSda,
  input  logic                       selReq,
  input  logic [IDX_W-1:0]           selSlot,
  input  logic                       nackEvt,
  input  logic                       crcEvt,
  input  logic [NUM_SLOTS-1:0]       clrMask,
  output logic [NUM_SLOTS-1:0]       gateEn,
  output logic [NUM_SLOTS-1:0]       slotRst,
  output logic [NUM_SLOTS-1:0]       isoMask,
  output logic [NUM_SLOTS-1:0]       nackFlag,
  output logic [NUM_SLOTS-1:0]       tmoFlag,
  output logic [NUM_SLOTS-1:0]       crcFlag,
  output logic [NUM_SLOTS*CNT_W-1:0] faultCnt,
  output logic                       alert,
  output logic                       recovering
);
  ctl_strobe_t strobe;
  logic brScl, brSda, busIdle, stuckLow;

  // connected branch lines as seen through the gate (high when none)
  assign brScl = &(slotScl | ~gateEn);
  assign brSda = &(slotSda | ~gateEn);

  slot_guard_monitor #(.IDLE_CYC(IDLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
    .clk(clk), .rstN(rstN), .hostScl(hostScl), .hostSda(hostSda),
    .brScl(brScl), .brSda(brSda), .watch(strobe.linkUp),
    .flush(strobe.faultCut), .busIdle(busIdle), .stuckLow(stuckLow)
  );

  slot_guard_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .TIMEOUT_CYC(TIMEOUT_CYC),
    .SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .selReq(selReq), .selSlot(selSlot),
    .slotScl(slotScl), .slotSda(slotSda), .isoMask(isoMask),
    .busIdle(busIdle), .stuckLow(stuckLow), .strobe(strobe),
    .gateEn(gateEn), .slotRst(slotRst), .recovering(recovering)
  );

  slot_guard_status #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_stat (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nackEvt(nackEvt),
    .crcEvt(crcEvt), .clrMask(clrMask), .isoMask(isoMask),
    .nackFlag(nackFlag), .tmoFlag(tmoFlag), .crcFlag(crcFlag),
    .faultCnt(faultCnt), .alert(alert)
  );
endmodule

// File: rtl/slot_guard_checker.sv
`timescale 1ns/1ps
module slot_guard_checker #(
  parameter int NUM_SLOTS   = 4,
  parameter int TIMEOUT_CYC = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] slotScl,
  input logic [NUM_SLOTS-1:0] slotSda,
  input logic [NUM_SLOTS-1:0] gateEn,
  input logic [NUM_SLOTS-1:0] isoMask,
  input logic                 nackEvt,
  input logic                 alert
);
  localparam int RW = $clog2(TIMEOUT_CYC + 3);
  logic [RW-1:0] sclRun, sdaRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclRun <= '0;
      sdaRun <= '0;
    end else begin
      sclRun <= (|(gateEn & ~slotScl)) ? ((sclRun == RW'(TIMEOUT_CYC + 2)) ? sclRun : sclRun + 1'b1) : '0;
      sdaRun <= (|(gateEn & ~slotSda)) ? ((sdaRun == RW'(TIMEOUT_CYC + 2)) ? sdaRun : sdaRun + 1'b1) : '0;
    end
  end

  a_r2_one_gate: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateEn));

  a_r4_settled_before_gate: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn != '0 && $past(gateEn) == '0) |-> &($past(slotScl & slotSda) | ~gateEn));

  a_r5_bounded_low: assert property (@(posedge clk) disable iff (!rstN)
    (sclRun <= RW'(TIMEOUT_CYC + 1)) && (sdaRun <= RW'(TIMEOUT_CYC + 1)));

  a_r7_isolated_not_gated: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn & isoMask) == '0);

  a_r9_alert_on_nack: assert property (@(posedge clk) disable iff (!rstN)
    (nackEvt && gateEn != '0) |=> alert);
endmodule

bind smbus_slot_guard slot_guard_checker #(
  .NUM_SLOTS(NUM_SLOTS), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .slotScl(slotScl), .slotSda(slotSda),
  .gateEn(gateEn), .isoMask(isoMask), .nackEvt(nackEvt), .alert(alert)
);

// File: tb/smbus_slot_guard_test.sv
`timescale 1ns/1ps
module smbus_slot_guard_test;
  localparam int N = 4, T = 32, ST = 6, IC = 4, RC = 4, CW = 3;

  logic clk = 1'b0, rstN = 1'b0, hostScl = 1'b1, hostSda = 1'b1;
  logic selReq = 1'b0, nackEvt = 1'b0, crcEvt = 1'b0;
  logic [N-1:0] slotScl = '1, slotSda = '1, clrMask = '0;
  logic [1:0] selSlot = '0;
  logic [N-1:0] gateEn, slotRst, isoMask, nackFlag, tmoFlag, crcFlag;
  logic [N*CW-1:0] faultCnt;
  logic alert, recovering;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smbus_slot_guard #(.NUM_SLOTS(N), .TIMEOUT_CYC(T), .SETTLE_CYC(ST),
    .IDLE_CYC(IC), .RST_CYC(RC), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .hostScl(hostScl), .hostSda(hostSda),
    .slotScl(slotScl), .slotSda(slotSda), .selReq(selReq), .selSlot(selSlot),
    .nackEvt(nackEvt), .crcEvt(crcEvt), .clrMask(clrMask), .gateEn(gateEn),
    .slotRst(slotRst), .isoMask(isoMask), .nackFlag(nackFlag), .tmoFlag(tmoFlag),
    .crcFlag(crcFlag), .faultCnt(faultCnt), .alert(alert), .recovering(recovering));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pick(int s);
    selSlot = 2'(s);
    selReq = 1'b1;
    tick(1);
    selReq = 1'b0;
  endtask

  task automatic pulse(bit isNack);
    if (isNack) nackEvt = 1'b1; else crcEvt = 1'b1;
    tick(1);
    nackEvt = 1'b0;
    crcEvt = 1'b0;
  endtask

  function automatic int cntOf(int i);
    return int'(faultCnt[i*CW +: CW]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seenRst, gateOffAtRst, isoAtRst, reconn;
    tick(4);
    rstN = 1'b1;
    tick(8);
    // R1 reset state
    chkEq("R1", "gates", int'(gateEn), 0);
    chkEq("R1", "alert", int'(alert), 0);
    chkEq("R1", "isolated", int'(isoMask), 0);
    chkEq("R1", "slot resets", int'(slotRst), 0);

    // R4 exact settle timing on an idle bus, R2 connection
    pick(1);
    tick(ST);
    chkEq("R4", "gate one edge before settle end", int'(gateEn), 0);
    tick(1);
    chkEq("R2", "slot1 connected", int'(gateEn), 4'b0010);

    // R4 low branch is never exposed
    slotSda[2] = 1'b0;
    pick(2);
    tick(12);
    chkEq("R4", "low slot2 kept off", int'(gateEn), 0);
    slotSda[2] = 1'b1;
    tick(ST + 3);
    chkEq("R2", "slot2 connected after release", int'(gateEn), 4'b0100);

    // R3 request between START and STOP waits for idle
    hostSda = 1'b0;
    tick(2);
    hostScl = 1'b0;
    tick(2);
    pick(0);
    for (int k = 0; k < 6; k++) begin
      hostScl = 1'b1; tick(2);
      hostScl = 1'b0; tick(2);
    end
    chkEq("R3", "gate held mid-transfer", int'(gateEn), 4'b0100);
    hostScl = 1'b1;
    tick(2);
    hostSda = 1'b1;
    tick(1);
    chkEq("R3", "gate held right after STOP", int'(gateEn), 4'b0100);
    tick(IC + ST + 4);
    chkEq("R3", "slot0 connected after idle", int'(gateEn), 4'b0001);

    // R8 NACK and data-error logging, R9 alert
    pulse(1'b1);
    chkEq("R8", "nack bit", int'(nackFlag), 4'b0001);
    chkEq("R8", "no crc bit", int'(crcFlag), 0);
    chkEq("R8", "count after nack", cntOf(0), 1);
    chkEq("R9", "alert with nack", int'(alert), 1);
    chkEq("R8", "still connected", int'(gateEn), 4'b0001);
    pulse(1'b0);
    chkEq("R8", "crc bit", int'(crcFlag), 4'b0001);
    chkEq("R8", "count after crc", cntOf(0), 2);

    // R11 per-slot clear
    clrMask = 4'b0010; tick(1); clrMask = '0;
    chkEq("R11", "other slot clear keeps slot0", int'(nackFlag), 4'b0001);
    clrMask = 4'b0001; tick(1); clrMask = '0;
    chkEq("R11", "nack cleared", int'(nackFlag), 0);
    chkEq("R11", "crc cleared", int'(crcFlag), 0);
    chkEq("R11", "count cleared", cntOf(0), 0);
    chkEq("R9", "alert low after clear", int'(alert), 0);

    // R10 saturation
    for (int k = 0; k < 9; k++) pulse(1'b1);
    chkEq("R10", "count saturates", cntOf(0), (1 << CW) - 1);
    clrMask = 4'b0001; tick(1); clrMask = '0;

    // R5 timeout on held SCL
    slotScl[0] = 1'b0;
    tick(T - 2);
    chkEq("R5", "gate before timeout", int'(gateEn), 4'b0001);
    tick(3);
    chkEq("R5", "gate opened", int'(gateEn), 0);
    chkEq("R5", "timeout bit", int'(tmoFlag), 4'b0001);
    chkEq("R5", "isolated", int'(isoMask), 4'b0001);
    chkEq("R5", "count", cntOf(0), 1);
    chkEq("R6", "recovering", int'(recovering), 1);
    seenRst = 1'b0;
    for (int k = 0; k < 200 && recovering; k++) begin
      if (slotRst[0]) seenRst = 1'b1;
      tick(1);
    end
    chkEq("R6", "reset pulse seen", int'(seenRst), 1);
    chkEq("R6", "failed re-enum keeps isolation", int'(isoMask), 4'b0001);
    chkEq("R6", "no gate after failure", int'(gateEn), 0);

    // R7 isolated slot ignored, others reachable
    pick(0);
    tick(20);
    chkEq("R7", "isolated select ignored", int'(gateEn), 0);
    pick(3);
    tick(ST + 4);
    chkEq("R7", "other slot reachable", int'(gateEn), 4'b1000);

    // R6 successful recovery
    slotSda[3] = 1'b0;
    gateOffAtRst = 1'b0; isoAtRst = 1'b0; seenRst = 1'b0;
    for (int k = 0; k < 200; k++) begin
      tick(1);
      if (slotRst[3]) begin
        seenRst = 1'b1;
        gateOffAtRst = (gateEn == '0);
        isoAtRst = isoMask[3];
        slotSda[3] = 1'b1;
        break;
      end
    end
    chkEq("R6", "reset on slot3", int'(seenRst), 1);
    chkEq("R6", "gate open during reset", int'(gateOffAtRst), 1);
    chkEq("R6", "isolated during reset", int'(isoAtRst), 1);
    reconn = 1'b0;
    for (int k = 0; k < 300; k++) begin
      tick(1);
      if (gateEn == 4'b1000) begin reconn = 1'b1; break; end
    end
    chkEq("R6", "slot3 reconnected", int'(reconn), 1);
    chkEq("R6", "isolation cleared", int'(isoMask[3]), 0);
    chkEq("R6", "timeout bit sticky", int'(tmoFlag[3]), 1);

    // R11 host clear lifts isolation
    slotScl[0] = 1'b1;
    clrMask = 4'b0001; tick(1); clrMask = '0;
    chkEq("R11", "slot0 isolation cleared", int'(isoMask[0]), 0);
    chkEq("R11", "slot0 timeout cleared", int'(tmoFlag[0]), 0);
    pick(0);
    tick(IC + ST + 4);
    chkEq("R11", "slot0 selectable again", int'(gateEn), 4'b0001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule